// File: doc/BRIEF.md
# SMI Request Controller with Re-entry Lock

This block holds a small byte-addressed group of registers (global status, global enable, a control byte, an acknowledge byte and a command byte) and turns three kinds of trigger into a one-cycle system management interrupt request. The triggers are a byte write to the command register, a global-release pulse from the neighbouring power-management event registers, and a strobe from an external APM command port. The CPU-side handling of the interrupt sits outside this block; it only sees the `smi_req` pulse.

A lock bit in the control byte, together with an internal "handler running" flag, keeps a second request from firing while a handler is still in progress. The handler signals completion by writing a one to bit 0 of the acknowledge byte. Writing the control byte with its release bit set sends a one-cycle BIOS-release pulse back to the event registers.

The register port is a single-cycle byte bus: a write happens on the rising clock edge where `bus_wr` is high; reads are combinational from `bus_addr` and return zero for any offset without a register.

Top module: `smi_ctl_lock`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00, the handler-running flag is clear, and `smi_req` and `bios_rls` are low.
- R2: Offset 0x28 is the global status byte; writing a 1 to any of bits 6..0 clears that bit, bit 7 always reads 0, and offset 0x29 reads 0x00 and ignores writes.
- R3: Offset 0x2A is the global enable byte and stores bits 6..0 of the written value with bit 7 reading 0; offset 0x2B reads 0x00 and ignores writes.
- R4: A write to offset 0x2F stores the byte (read back at 0x2F), sets status bit 6, and requests an SMI when enable bit 6 is set.
- R5: A high cycle on `grel_pulse` sets status bit 5 and requests an SMI when enable bit 5 is set.
- R6: A high cycle on `apm_cmd_stb` requests an SMI without touching the status byte.
- R7: A request produces an SMI only while control bit 0 is set; status bits are still set when it is clear.
- R8: When control bit 4 (lock) is set and the handler-running flag is set, requests produce no SMI; with the lock clear a request while running produces another SMI.
- R9: Each SMI sets the handler-running flag; a write to offset 0x2D with bit 0 set clears it, a write with bit 0 clear leaves it, and an SMI raised in the same cycle as the acknowledge wins.
- R10: Offset 0x2C (control) reads back the stored byte with bit 0 replaced by the handler-running flag and bit 4 showing the lock; offset 0x2D reads 0x00.
- R11: A write to 0x2C with bit 1 set drives `bios_rls` high for exactly the following cycle.
- R12: `smi_req` is high for one cycle per raised SMI, in the cycle after the triggering edge.
- R13: When a status bit is set by an event and cleared by a write in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 8 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| grel_pulse | input | 1 | Global-release pulse from the event registers |
| apm_cmd_stb | input | 1 | APM command port write strobe |
| smi_req | output | 1 | One-cycle SMI request |
| bios_rls | output | 1 | One-cycle BIOS-release pulse to the event registers |

## Verification
The handler-running flag is internal, but it shows at the ports in two ways: it appears as bit 0 of the control readback right after the edge that changes it, and, with the lock set, it decides whether the next trigger produces an `smi_req` pulse. A stuck or wrongly cleared flag therefore shows up either in the very next read of 0x2C or as a missing or extra pulse on the first trigger after it. A status or enable bit that is lost or kept when it should not be shows in the next read of 0x28 or 0x2A, and a wrong enable shows one cycle after the matching event as a wrong `smi_req`. The bench compares every cycle's pulses and readbacks against its own model over a long random run that mixes all three triggers with acknowledges and lock changes.

// File: rtl/smi_pkg.sv
// Package: shared offsets, bit positions and widths for the SMI controller.
// Assumes a byte-wide register bus with 8-bit offsets.
package smi_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int EVT_BITS  = 7;

    localparam logic [ADDR_W-1:0] OFS_STS_LO = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_STS_HI = 8'h29;
    localparam logic [ADDR_W-1:0] OFS_EN_LO  = 8'h2A;
    localparam logic [ADDR_W-1:0] OFS_EN_HI  = 8'h2B;
    localparam logic [ADDR_W-1:0] OFS_CTL    = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h2D;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h2F;

    localparam int CTL_SMI_EN   = 0;
    localparam int CTL_BIOS_RLS = 1;
    localparam int CTL_LOCK     = 4;
    localparam int ACK_BIT      = 0;
    localparam int EVT_GREL     = 5;
    localparam int EVT_CMD      = 6;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STS,
        SEL_EN,
        SEL_CTL,
        SEL_CMD
    } rd_sel_e;
endpackage

// File: rtl/smi_evt_regs.sv
// Module: global status (write-one-to-clear) and global enable bytes.
// Produces the event-side trigger: a status event whose enable bit is set.
// Assumes set and clear in the same cycle resolve to set.
module smi_evt_regs #(
    parameter int EVT_BITS  = 7,
    parameter int GREL_BIT  = 5,
    parameter int CMD_BIT   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_sts,
    input  logic                wr_en,
    input  logic [EVT_BITS-1:0] wdata,
    input  logic                set_cmd,
    input  logic                set_grel,
    output logic [EVT_BITS-1:0] sts_q,
    output logic [EVT_BITS-1:0] en_q,
    output logic                evt_trig
);
    logic [EVT_BITS-1:0] set_vec;
    logic [EVT_BITS-1:0] clr_vec;

    // Build per-bit set and clear vectors from events and the bus.
    always_comb begin
        set_vec           = '0;
        set_vec[CMD_BIT]  = set_cmd;
        set_vec[GREL_BIT] = set_grel;
        clr_vec           = wr_sts ? wdata : '0;
    end

    // One status flop per event bit; a set beats a clear.
    for (genvar i = 0; i < EVT_BITS; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (!rst_n)          sts_q[i] <= 1'b0;
            else if (set_vec[i]) sts_q[i] <= 1'b1;
            else if (clr_vec[i]) sts_q[i] <= 1'b0;
        end
    end

    // Enable byte: plain storage of the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata;
    end

    // Event trigger uses the enable value from before this edge.
    always_comb begin
        evt_trig = (set_cmd & en_q[CMD_BIT]) | (set_grel & en_q[GREL_BIT]);
    end
endmodule

// File: rtl/smi_ctl_reg.sv
// Module: control byte storage and the BIOS-release pulse generator.
// Assumes the release pulse is registered, one cycle after the write edge.
module smi_ctl_reg #(
    parameter int DATA_W   = 8,
    parameter int RLS_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_q,
    output logic              bios_rls
);
    // Store the control byte as written.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= wdata;
    end

    // Emit a single-cycle release pulse on a write with the release bit.
    always_ff @(posedge clk) begin
        if (!rst_n) bios_rls <= 1'b0;
        else        bios_rls <= wr_ctl & wdata[RLS_BIT];
    end
endmodule

// File: rtl/smi_gate.sv
// Module: SMI gating with re-entry lock and handler-running flag.
// Assumes gating uses register values from before the current edge and
// that a raise in the same cycle as an acknowledge leaves the flag set.
module smi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic smi_en,
    input  logic lock,
    input  logic ack,
    output logic smi_req,
    output logic active
);
    logic fire;

    // Decide whether a trigger may raise an SMI this cycle.
    always_comb begin
        fire = trig & smi_en & (~lock | ~active);
    end

    // Track whether a handler is running.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= 1'b0;
        else if (fire) active <= 1'b1;
        else if (ack)  active <= 1'b0;
    end

    // Register the request so it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_req <= 1'b0;
        else        smi_req <= fire;
    end
endmodule

// File: rtl/smi_ctl_lock.sv
// Module: top of the SMI controller; decodes the byte bus, holds the
// command byte and builds the readback. Reads are combinational.
module smi_ctl_lock
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              grel_pulse,
    input  logic              apm_cmd_stb,
    output logic              smi_req,
    output logic              bios_rls
);
    localparam int PAD_W = DATA_W - EVT_BITS;

    logic                wr_sts, wr_en, wr_ctl, wr_ack, wr_cmd;
    logic [EVT_BITS-1:0] sts_q, en_q;
    logic [DATA_W-1:0]   ctl_q, cmd_q;
    logic                evt_trig, act_q;
    rd_sel_e             rd_sel;

    // Decode write strobes per register offset.
    always_comb begin
        wr_sts = bus_wr && (bus_addr == OFS_STS_LO);
        wr_en  = bus_wr && (bus_addr == OFS_EN_LO);
        wr_ctl = bus_wr && (bus_addr == OFS_CTL);
        wr_ack = bus_wr && (bus_addr == OFS_ACK) && bus_wdata[ACK_BIT];
        wr_cmd = bus_wr && (bus_addr == OFS_CMD);
    end

    smi_evt_regs #(
        .EVT_BITS (EVT_BITS),
        .GREL_BIT (EVT_GREL),
        .CMD_BIT  (EVT_CMD)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sts   (wr_sts),
        .wr_en    (wr_en),
        .wdata    (bus_wdata[EVT_BITS-1:0]),
        .set_cmd  (wr_cmd),
        .set_grel (grel_pulse),
        .sts_q    (sts_q),
        .en_q     (en_q),
        .evt_trig (evt_trig)
    );

    smi_ctl_reg #(
        .DATA_W  (DATA_W),
        .RLS_BIT (CTL_BIOS_RLS)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_ctl),
        .wdata    (bus_wdata),
        .ctl_q    (ctl_q),
        .bios_rls (bios_rls)
    );

    smi_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (evt_trig | apm_cmd_stb),
        .smi_en  (ctl_q[CTL_SMI_EN]),
        .lock    (ctl_q[CTL_LOCK]),
        .ack     (wr_ack),
        .smi_req (smi_req),
        .active  (act_q)
    );

    // Hold the last byte written to the command register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (wr_cmd) cmd_q <= bus_wdata;
    end

    // Select which register the read offset points at.
    always_comb begin
        unique case (bus_addr)
            OFS_STS_LO: rd_sel = SEL_STS;
            OFS_EN_LO:  rd_sel = SEL_EN;
            OFS_CTL:    rd_sel = SEL_CTL;
            OFS_CMD:    rd_sel = SEL_CMD;
            default:    rd_sel = SEL_NONE;
        endcase
    end

    // Build read data; control shows the running flag in its enable slot.
    always_comb begin
        bus_rdata = '0;
        case (rd_sel)
            SEL_STS: bus_rdata = {{PAD_W{1'b0}}, sts_q};
            SEL_EN:  bus_rdata = {{PAD_W{1'b0}}, en_q};
            SEL_CTL: begin
                bus_rdata             = ctl_q;
                bus_rdata[CTL_SMI_EN] = act_q;
                bus_rdata[CTL_LOCK]   = ctl_q[CTL_LOCK];
            end
            SEL_CMD: bus_rdata = cmd_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smi_ctl_lock_chk.sv
// Checker: temporal properties of the SMI controller, bound to the top.
module smi_ctl_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       grel_pulse,
    input logic [6:0] sts_q,
    input logic [7:0] ctl_q,
    input logic       act_q,
    input logic       smi_req,
    input logic       bios_rls
);
    // R8: locked while running means no new request.
    p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[4] && act_q) |=> !smi_req);

    // R7: no request while the SMI enable bit is clear.
    p_enable_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[0] |=> !smi_req);

    // R9: every request leaves the running flag set.
    p_req_sets_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> act_q);

    // R11: a release pulse follows a control write with bit 1 set.
    p_bios_rls_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bios_rls |-> $past(bus_wr && bus_addr == 8'h2C && bus_wdata[1]));

    // R5: the release event always leaves status bit 5 set.
    p_grel_sets_sts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grel_pulse |=> sts_q[5]);
endmodule

bind smi_ctl_lock smi_ctl_lock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .grel_pulse (grel_pulse),
    .sts_q      (sts_q),
    .ctl_q      (ctl_q),
    .act_q      (act_q),
    .smi_req    (smi_req),
    .bios_rls   (bios_rls)
);

// File: tb/smi_ctl_lock_tb.sv
module smi_ctl_lock_tb;
    localparam int CLK_PERIOD = 20;
    localparam int N_RAND     = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       grel_pulse = 1'b0;
    logic       apm_cmd_stb = 1'b0;
    logic       smi_req;
    logic       bios_rls;

    int checks = 0;
    int fails  = 0;

    // Bench-side model state.
    logic [6:0] m_sts = '0;
    logic [6:0] m_en  = '0;
    logic [7:0] m_ctl = '0;
    logic [7:0] m_cmd = '0;
    logic       m_act = 1'b0;
    logic       e_smi = 1'b0;
    logic       e_rls = 1'b0;

    smi_ctl_lock u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .grel_pulse  (grel_pulse),
        .apm_cmd_stb (apm_cmd_stb),
        .smi_req     (smi_req),
        .bios_rls    (bios_rls)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h28:   return {1'b0, m_sts};
            8'h2A:   return {1'b0, m_en};
            8'h2C:   return {m_ctl[7:1], m_act};
            8'h2F:   return m_cmd;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Combinational read in the low clock phase.
    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    // One bus cycle: drive at negedge, update model, compare pulses after edge.
    task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                        input logic g, input logic p, input string tag);
        logic cmd_w, trig, fire;
        bus_wr = w; bus_addr = a; bus_wdata = d; grel_pulse = g; apm_cmd_stb = p;
        cmd_w = w && a == 8'h2F;
        trig  = (cmd_w && m_en[6]) || (g && m_en[5]) || p;
        fire  = trig && m_ctl[0] && (!m_ctl[4] || !m_act);
        e_smi = fire;
        e_rls = w && a == 8'h2C && d[1];
        if (w && a == 8'h28) m_sts = m_sts & ~d[6:0];
        if (cmd_w) m_sts[6] = 1'b1;
        if (g)     m_sts[5] = 1'b1;
        if (w && a == 8'h2A) m_en  = d[6:0];
        if (w && a == 8'h2C) m_ctl = d;
        if (cmd_w)           m_cmd = d;
        if (fire) m_act = 1'b1;
        else if (w && a == 8'h2D && d[0]) m_act = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; grel_pulse = 1'b0; apm_cmd_stb = 1'b0;
        chk({7'b0, smi_req},  {7'b0, e_smi}, {tag, " smi_req R12"});
        chk({7'b0, bios_rls}, {7'b0, e_rls}, {tag, " bios_rls R11"});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] ra;
        logic [7:0] rd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk({7'b0, smi_req}, 8'h00, "R1 smi_req");
        chk({7'b0, bios_rls}, 8'h00, "R1 bios_rls");
        rd_chk(8'h28, 8'h00, "R1 status");
        rd_chk(8'h2A, 8'h00, "R1 enable");
        rd_chk(8'h2C, 8'h00, "R1 control");
        rd_chk(8'h2F, 8'h00, "R1 command");

        // R3: enable masking and high byte
        step(1, 8'h2A, 8'hFF, 0, 0, "R3");
        rd_chk(8'h2A, 8'h7F, "R3 enable");
        step(1, 8'h2B, 8'hFF, 0, 0, "R3");
        rd_chk(8'h2B, 8'h00, "R3 enable hi");
        rd_chk(8'h2A, 8'h7F, "R3 enable kept");

        // R11: control write with release bit, lock and enable set
        step(1, 8'h2C, 8'h13, 0, 0, "R11");
        chk({7'b0, bios_rls}, 8'h01, "R11 pulse");
        rd_chk(8'h2C, 8'h12, "R10 readback idle");
        step(0, 8'h00, 8'h00, 0, 0, "R11");
        chk({7'b0, bios_rls}, 8'h00, "R11 one cycle");

        // R4: command write raises SMI
        step(1, 8'h2F, 8'h5A, 0, 0, "R4");
        chk({7'b0, smi_req}, 8'h01, "R4 smi");
        rd_chk(8'h2F, 8'h5A, "R4 command");
        rd_chk(8'h28, 8'h40, "R4 status");
        rd_chk(8'h2C, 8'h13, "R10 readback active");

        // R8: locked and running blocks a release event
        step(0, 8'h00, 8'h00, 1, 0, "R8");
        chk({7'b0, smi_req}, 8'h00, "R8 blocked");
        rd_chk(8'h28, 8'h60, "R5 status set while blocked");

        // R9: acknowledge with bit0 clear, then set
        step(1, 8'h2D, 8'hFE, 0, 0, "R9");
        rd_chk(8'h2C, 8'h13, "R9 no ack");
        step(1, 8'h2D, 8'h01, 0, 0, "R9");
        rd_chk(8'h2C, 8'h12, "R9 ack");
        rd_chk(8'h2D, 8'h00, "R10 ack byte");

        // R6: APM strobe raises SMI without status change
        step(0, 8'h00, 8'h00, 0, 1, "R6");
        chk({7'b0, smi_req}, 8'h01, "R6 smi");
        rd_chk(8'h28, 8'h60, "R6 status");
        step(0, 8'h00, 8'h00, 0, 0, "R12");
        chk({7'b0, smi_req}, 8'h00, "R12 single pulse");

        // R8: lock clear lets a second SMI through while running
        step(1, 8'h2C, 8'h01, 0, 0, "R8");
        step(0, 8'h00, 8'h00, 0, 1, "R8");
        chk({7'b0, smi_req}, 8'h01, "R8 unlocked retrigger");

        // R9: raise in same cycle as ack keeps flag set
        step(1, 8'h2D, 8'h01, 0, 1, "R9");
        chk({7'b0, smi_req}, 8'h01, "R9 same-cycle smi");
        rd_chk(8'h2C, 8'h01, "R9 raise wins");

        // R7: enable clear blocks SMI, status still set
        step(1, 8'h2C, 8'h00, 0, 0, "R7");
        step(1, 8'h28, 8'h7F, 0, 0, "R2");
        step(0, 8'h00, 8'h00, 1, 1, "R7");
        chk({7'b0, smi_req}, 8'h00, "R7 disabled");
        rd_chk(8'h28, 8'h20, "R7 status");

        // R2: W1C with bit 7 ignored, high byte ignored
        step(1, 8'h28, 8'hA0, 0, 0, "R2");
        rd_chk(8'h28, 8'h00, "R2 clear");
        step(1, 8'h2F, 8'h11, 0, 0, "R2");
        step(1, 8'h29, 8'hFF, 0, 0, "R2");
        rd_chk(8'h28, 8'h40, "R2 hi byte ignored");
        rd_chk(8'h29, 8'h00, "R2 hi byte reads zero");

        // R13: set and clear in one cycle
        step(1, 8'h28, 8'h20, 1, 0, "R13");
        rd_chk(8'h28, 8'h60, "R13 set wins");

        // R5: release event raises SMI with enable bit 5
        step(1, 8'h2A, 8'h20, 0, 0, "R5");
        step(1, 8'h2C, 8'h01, 0, 0, "R5");
        step(0, 8'h00, 8'h00, 1, 0, "R5");
        chk({7'b0, smi_req}, 8'h01, "R5 smi");

        // Random mix against the model
        for (int i = 0; i < N_RAND; i++) begin
            logic w;
            case ($urandom_range(0, 7))
                0: ra = 8'h28;
                1: ra = 8'h2A;
                2: ra = 8'h2C;
                3: ra = 8'h2D;
                4: ra = 8'h2F;
                5: ra = 8'h29;
                6: ra = 8'h2B;
                default: ra = 8'h10;
            endcase
            rd = 8'($urandom);
            if (ra == 8'h2C && $urandom_range(0, 3) != 0) rd[0] = 1'b1;
            w = ($urandom_range(0, 2) != 0);
            step(w, ra, rd, ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0), "rand");
            rd_chk(8'h28, model_read(8'h28), "R2 rand status");
            rd_chk(8'h2A, model_read(8'h2A), "R3 rand enable");
            rd_chk(8'h2C, model_read(8'h2C), "R10 rand control");
            rd_chk(8'h2F, model_read(8'h2F), "R4 rand command");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule